// File: doc/BRIEF.md
# Shared-Line ADC Serial Reader

This block is the host side of a read link to a 24-bit delta-sigma converter. The converter uses one line for two jobs. A falling level on the line says a conversion result is ready. After that, the same line carries the result bits, one per serial clock pulse that the host drives. The block synchronises the line and waits for a falling edge that follows a seen-high level. It then issues serial clock pulses whose high and low phases each last a set number of system clocks. It samples one bit at the end of every high phase, most significant bit first.

A read may take fewer than all 24 bits. When the extra-pulse option is on, one more clock pulse follows the last data pulse. On the converter this pulse drives the line high, so polling for readiness can start again cleanly. The finished word is presented with a one-cycle valid strobe. A read that is still running when the conversion-period timer runs out is dropped, and a sticky overrun flag is raised. Software clears that flag.

The controller has seven states. ARM waits for the line to read high and then moves to IDLE. IDLE waits for a falling edge and then moves to HIGH, latching the read length. HIGH holds the serial clock high and samples on its last cycle, then moves to LOW. LOW holds the clock low. At its end it returns to HIGH for the next bit, or moves to FHIGH when the extra pulse is enabled, or otherwise to DONE. FHIGH and FLOW form the extra pulse, and FLOW leads to DONE. DONE lasts one cycle and returns to ARM. A timer expiry in HIGH, LOW, FHIGH or FLOW sends the controller straight to ARM.

Top module: `adcrd_reader`

## Requirements
- R1: While reset is held, and in the first cycle after reset, sclk_o is 0, valid_o is 0, overrun_o is 0 and data_o is all zeros.
- R2: No serial clock pulse is issued until the line has been seen high and has then fallen. A line held low from reset produces no pulse.
- R3: Every serial clock pulse is high for exactly HALF_CYC system cycles and then low for exactly HALF_CYC cycles. Pulses of one read follow back to back.
- R4: With two synchroniser stages, the first serial clock rise comes 3 cycles after the line falls. Each bit is sampled on the last cycle of its high phase. The k-th bit taken (k starting at 1) lands in data_o[DATA_W-k], so the first bit lands in data_o[23].
- R5: len_i is the number of bits to take. It is captured at the ready edge, so later changes to it do not affect the read in progress. Values 0 or above 24 mean 24. The data_o bits that are not taken read 0.
- R6: valid_o is a single-cycle pulse. Its cycle is 3 + 2*HALF_CYC*(n + f) cycles after the line falls, where n is the effective length and f is 1 when the extra pulse is issued. data_o changes only in a cycle where valid_o is 1 and holds otherwise.
- R7: When force_hi_i is 1 at the ready edge, exactly one extra serial clock pulse follows the data pulses, giving n+1 rises. When it is 0, there are exactly n rises.
- R8: When a read has not reached DONE within CONV_CYC cycles of its first clock rise, it is dropped. The clock goes low, no valid_o is given, and overrun_o is 1 from cycle CONV_CYC+3 after the line falls. A read that finishes in time leaves overrun_o at 0.
- R9: overrun_o stays 1 until ovr_clr_i is pulsed. A timeout in the same cycle as the clear wins.
- R10: After a read, a new read needs the line to be seen high again. A line that stays low after the last bit starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rdy_line_i | input | 1 | Shared ready/data line from the converter |
| len_i | input | 5 | Bits to take per read (0 or >24 means 24) |
| force_hi_i | input | 1 | Issue one extra clock pulse after the data |
| ovr_clr_i | input | 1 | Clears the overrun flag |
| sclk_o | output | 1 | Serial clock to the converter |
| data_o | output | 24 | Last captured word, first bit in the MSB |
| valid_o | output | 1 | One-cycle strobe for a new data_o |
| overrun_o | output | 1 | Sticky timeout flag |

## Verification
Every result is timed from the system-clock edge after the line falls. The first serial clock rise is due 3 cycles later. The first fall and the second rise follow it at gaps of HALF_CYC cycles each. valid_o is due 3 + 2*HALF_CYC*(n+f) cycles after the line falls, and the overrun of a timed-out read is due CONV_CYC+3 cycles after it. The bench drives inputs on falling clock edges and counts falling edges from the one where the line drops. It compares the exact count at which each event first appears against these formulas, so an early or late result fails as surely as a wrong value.

// File: rtl/adcrd_pkg.sv
package adcrd_pkg;

    typedef enum logic [2:0] {
        ST_ARM   = 3'd0,
        ST_IDLE  = 3'd1,
        ST_HIGH  = 3'd2,
        ST_LOW   = 3'd3,
        ST_FHIGH = 3'd4,
        ST_FLOW  = 3'd5,
        ST_DONE  = 3'd6
    } rd_state_t;

endpackage

// File: rtl/adcrd_sync.sv
module adcrd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic level_o,
    output logic fall_o
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= line_i;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], line_i};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= chain_q[STAGES-1];
    end

    assign level_o = chain_q[STAGES-1];
    assign fall_o  = prev_q & ~chain_q[STAGES-1];
endmodule

// File: rtl/adcrd_halfcnt.sv
module adcrd_halfcnt #(
    parameter int HALF_CYC = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic last_o
);
    localparam int CW = $clog2(HALF_CYC + 1);
    logic [CW-1:0] cnt_q;

    assign last_o = run_i && (cnt_q == CW'(HALF_CYC - 1));

    always_ff @(posedge clk) begin
        if (!rst_n)                cnt_q <= '0;
        else if (!run_i || last_o) cnt_q <= '0;
        else                       cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/adcrd_timer.sv
module adcrd_timer #(
    parameter int LIMIT = 625000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic expire_o
);
    localparam int TW = $clog2(LIMIT + 1);
    logic [TW-1:0] cnt_q;

    assign expire_o = run_i && (cnt_q == TW'(LIMIT - 1));

    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (!run_i) cnt_q <= '0;
        else if (!expire_o) cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/adcrd_capture.sv
module adcrd_capture #(
    parameter int DATA_W = 24,
    parameter int IW     = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              wr_i,
    input  logic [IW-1:0]     idx_i,
    input  logic              bit_i,
    output logic [DATA_W-1:0] word_o
);
    generate
        for (genvar b = 0; b < DATA_W; b++) begin : g_bit
            localparam int POS = DATA_W - 1 - b;
            always_ff @(posedge clk) begin
                if (!rst_n)                                word_o[POS] <= 1'b0;
                else if (clear_i)                          word_o[POS] <= 1'b0;
                else if (wr_i && (idx_i == IW'(b)))        word_o[POS] <= bit_i;
            end
        end
    endgenerate
endmodule

// File: rtl/adcrd_reader.sv
module adcrd_reader
    import adcrd_pkg::*;
#(
    parameter int DATA_W      = 24,
    parameter int HALF_CYC    = 5,
    parameter int CONV_CYC    = 625000,
    parameter int SYNC_STAGES = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          rdy_line_i,
    input  logic [$clog2(DATA_W+1)-1:0]   len_i,
    input  logic                          force_hi_i,
    input  logic                          ovr_clr_i,
    output logic                          sclk_o,
    output logic [DATA_W-1:0]             data_o,
    output logic                          valid_o,
    output logic                          overrun_o
);
    localparam int LEN_W = $clog2(DATA_W + 1);

    rd_state_t          state_q, state_nx;
    logic [LEN_W-1:0]   bit_cnt_q;
    logic [LEN_W-1:0]   len_q;
    logic [LEN_W-1:0]   len_eff;
    logic               force_q;
    logic               line_lvl, line_fall;
    logic               in_read, ph_last, tmo;
    logic               take_bit, start_rd;
    logic [DATA_W-1:0]  cap_word;

    adcrd_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_i  (rdy_line_i),
        .level_o (line_lvl),
        .fall_o  (line_fall)
    );

    assign in_read = (state_q == ST_HIGH) || (state_q == ST_LOW) ||
                     (state_q == ST_FHIGH) || (state_q == ST_FLOW);

    adcrd_halfcnt #(.HALF_CYC(HALF_CYC)) u_half (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (in_read),
        .last_o (ph_last)
    );

    adcrd_timer #(.LIMIT(CONV_CYC)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (in_read),
        .expire_o (tmo)
    );

    assign start_rd = (state_q == ST_IDLE) && line_fall;
    assign take_bit = (state_q == ST_HIGH) && ph_last && !tmo;

    adcrd_capture #(.DATA_W(DATA_W), .IW(LEN_W)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (start_rd),
        .wr_i    (take_bit),
        .idx_i   (bit_cnt_q),
        .bit_i   (line_lvl),
        .word_o  (cap_word)
    );

    always_comb begin
        if ((len_i == '0) || (int'(len_i) > DATA_W)) len_eff = LEN_W'(DATA_W);
        else                                          len_eff = len_i;
    end

    // next-state decode
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_ARM:   if (line_lvl) state_nx = ST_IDLE;
            ST_IDLE:  if (line_fall) state_nx = ST_HIGH;
            ST_HIGH: begin
                if (tmo)          state_nx = ST_ARM;
                else if (ph_last) state_nx = ST_LOW;
            end
            ST_LOW: begin
                if (tmo) state_nx = ST_ARM;
                else if (ph_last) begin
                    if (bit_cnt_q != len_q) state_nx = ST_HIGH;
                    else if (force_q)       state_nx = ST_FHIGH;
                    else                    state_nx = ST_DONE;
                end
            end
            ST_FHIGH: begin
                if (tmo)          state_nx = ST_ARM;
                else if (ph_last) state_nx = ST_FLOW;
            end
            ST_FLOW: begin
                if (tmo)          state_nx = ST_ARM;
                else if (ph_last) state_nx = ST_DONE;
            end
            ST_DONE:  state_nx = ST_ARM;
            default:  state_nx = ST_ARM;
        endcase
    end

    // state register and read bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_ARM;
            bit_cnt_q <= '0;
            len_q     <= '0;
            force_q   <= 1'b0;
        end else begin
            state_q <= state_nx;
            if (start_rd) begin
                bit_cnt_q <= '0;
                len_q     <= len_eff;
                force_q   <= force_hi_i;
            end else if (take_bit) begin
                bit_cnt_q <= bit_cnt_q + 1'b1;
            end
        end
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_o    <= 1'b0;
            valid_o   <= 1'b0;
            data_o    <= '0;
            overrun_o <= 1'b0;
        end else begin
            sclk_o  <= (state_nx == ST_HIGH) || (state_nx == ST_FHIGH);
            valid_o <= (state_nx == ST_DONE);
            if (state_nx == ST_DONE) data_o <= cap_word;
            if (tmo)            overrun_o <= 1'b1;
            else if (ovr_clr_i) overrun_o <= 1'b0;
        end
    end
endmodule

// File: rtl/adcrd_reader_chk.sv
module adcrd_reader_chk #(
    parameter int DATA_W   = 24,
    parameter int HALF_CYC = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sclk_o,
    input logic              valid_o,
    input logic [DATA_W-1:0] data_o,
    input logic              overrun_o,
    input logic              ovr_clr_i
);
    localparam int RW = $clog2(HALF_CYC + 1);
    logic [RW-1:0] hi_run, lo_run;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_run <= '0;
            lo_run <= RW'(HALF_CYC);
        end else if (sclk_o) begin
            lo_run <= '0;
            if (hi_run != RW'(HALF_CYC)) hi_run <= hi_run + 1'b1;
        end else begin
            hi_run <= '0;
            if (lo_run != RW'(HALF_CYC)) lo_run <= lo_run + 1'b1;
        end
    end

    AST_SCLK_HIGH_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk_o) |-> (hi_run == RW'(HALF_CYC))); // R3
    AST_SCLK_LOW_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk_o) |-> (lo_run == RW'(HALF_CYC))); // R3
    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o); // R6
    AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(data_o) |-> valid_o); // R6
    AST_NO_CLK_AT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> !sclk_o); // R7
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun_o && !ovr_clr_i) |=> overrun_o); // R9
endmodule

bind adcrd_reader adcrd_reader_chk #(.DATA_W(DATA_W), .HALF_CYC(HALF_CYC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk_o    (sclk_o),
    .valid_o   (valid_o),
    .data_o    (data_o),
    .overrun_o (overrun_o),
    .ovr_clr_i (ovr_clr_i)
);

// File: tb/adcrd_reader_test.sv
`timescale 1ns/1ps
module adcrd_reader_test;
    localparam int H      = 5;
    localparam int CONV_T = 100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  rd_len = 5'd24;
    logic        force_hi = 1'b0;
    logic        ovr_clr = 1'b0;
    logic        line, to_line = 1'b1;
    logic        sclk, valid, ovr;
    logic [23:0] dout;
    logic        to_sclk, to_valid, to_ovr;
    logic [23:0] to_dout;

    logic        upd = 1'b0;
    logic [23:0] mdl_word = '0;
    int          rises = 0;
    int          mdl_base = 0;
    int          errors = 0;
    int          checks = 0;
    bit          finished = 1'b0;

    always #10 clk = ~clk;

    // converter model: low when ready, bit per rise, high after 24
    always @(posedge sclk) rises <= rises + 1;
    always_comb begin
        int k;
        k = rises - mdl_base;
        if (upd)          line = 1'b1;
        else if (k == 0)  line = 1'b0;
        else if (k <= 24) line = mdl_word[24-k];
        else              line = 1'b1;
    end

    adcrd_reader #(.HALF_CYC(H)) uut (
        .clk(clk), .rst_n(rst_n), .rdy_line_i(line), .len_i(rd_len),
        .force_hi_i(force_hi), .ovr_clr_i(ovr_clr), .sclk_o(sclk),
        .data_o(dout), .valid_o(valid), .overrun_o(ovr)
    );

    adcrd_reader #(.HALF_CYC(H), .CONV_CYC(CONV_T)) uut_to (
        .clk(clk), .rst_n(rst_n), .rdy_line_i(to_line), .len_i(rd_len),
        .force_hi_i(force_hi), .ovr_clr_i(ovr_clr), .sclk_o(to_sclk),
        .data_o(to_dout), .valid_o(to_valid), .overrun_o(to_ovr)
    );

    // word, length, extra pulse
    localparam logic [29:0] VEC [7] = '{
        {24'hA53C96, 5'd24, 1'b0},
        {24'h5AC369, 5'd24, 1'b1},
        {24'hFFFFFF, 5'd24, 1'b1},
        {24'h800001, 5'd8,  1'b0},
        {24'h123456, 5'd0,  1'b1},
        {24'hC0FFEE, 5'd31, 1'b0},
        {24'h7FFFFE, 5'd1,  1'b1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_read(input logic [23:0] w, input logic [4:0] len, input logic f,
                           input bit use_to);
        int eff, n, r1, fl, r2, to_v;
        logic ps;
        logic [23:0] exp;
        eff = (len == 0 || len > 24) ? 24 : int'(len);
        exp = w & ~(24'hFFFFFF >> eff);
        @(negedge clk);
        rd_len = len; force_hi = f; upd = 1'b1;
        repeat (6) @(negedge clk);
        mdl_word = w; mdl_base = rises; upd = 1'b0;
        if (use_to) to_line = 1'b0;
        n = 0; r1 = -1; fl = -1; r2 = -1; ps = 1'b0; to_v = 0;
        while (n < 3000) begin
            @(negedge clk);
            n++;
            if (n == 5) rd_len = 5'd1;  // must not affect this read (R5)
            if (sclk && !ps) begin
                if (r1 < 0) r1 = n; else if (r2 < 0) r2 = n;
            end
            if (!sclk && ps && fl < 0) fl = n;
            ps = sclk;
            if (to_valid) to_v = 1;
            if (valid) break;
        end
        chk("R4 first rise", r1, 3);
        if (eff + int'(f) >= 2) begin
            chk("R3 high phase", fl - r1, H);
            chk("R3 low phase", r2 - fl, H);
        end
        chk("R6 valid latency", n, 3 + 2*H*(eff + int'(f)));
        chk("R5 R4 data", dout, exp);
        chk("R7 pulse count", rises - mdl_base, eff + int'(f));
        chk("R8 no overrun", ovr, 0);
        @(negedge clk);
        chk("R6 valid single", valid, 0);
        if (use_to) begin
            chk("R8 short read valid", to_v, 1);
            chk("R8 short read no overrun", to_ovr, 0);
            to_line = 1'b1;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int n, n_o, to_v;
        repeat (3) @(negedge clk);
        chk("R1 sclk in reset", sclk, 0);
        chk("R1 valid in reset", valid, 0);
        chk("R1 overrun in reset", ovr, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 data after reset", dout, 0);
        chk("R1 sclk after reset", sclk, 0);

        // line low since reset: nothing may start
        repeat (40) @(negedge clk);
        chk("R2 no pulse without high", rises, 0);

        for (int i = 0; i < 7; i++)
            do_read(VEC[i][29:6], VEC[i][5:1], VEC[i][0], 1'b0);

        // last bit 0, no extra pulse: line stays low
        do_read(24'h0F0F0E, 5'd24, 1'b0, 1'b0);
        begin
            int r0, v;
            r0 = rises; v = 0;
            for (int c = 0; c < 60; c++) begin
                @(negedge clk);
                if (valid) v = 1;
            end
            chk("R10 no rearm while low", rises - r0, 0);
            chk("R10 no valid while low", v, 0);
        end

        // clear any overrun on the short-timeout instance
        @(negedge clk); ovr_clr = 1'b1;
        @(negedge clk); ovr_clr = 1'b0;
        chk("R9 clear", to_ovr, 0);

        do_read(24'h3C3C3C, 5'd4, 1'b0, 1'b1);

        // full read on the short-timeout instance must time out
        @(negedge clk);
        rd_len = 5'd24; force_hi = 1'b0; upd = 1'b1;
        repeat (6) @(negedge clk);
        mdl_word = 24'h96A5C3; mdl_base = rises; upd = 1'b0; to_line = 1'b0;
        n = 0; n_o = -1; to_v = 0;
        while (n < 3000) begin
            @(negedge clk);
            n++;
            if (to_ovr && n_o < 0) n_o = n;
            if (to_valid) to_v = 1;
            if (valid) break;
        end
        chk("R8 overrun cycle", n_o, CONV_T + 3);
        chk("R8 no valid on timeout", to_v, 0);
        chk("R8 sclk low after abort", to_sclk, 0);
        chk("R6 R5 normal read alongside", dout, 24'h96A5C3);
        repeat (20) @(negedge clk);
        chk("R9 overrun sticky", to_ovr, 1);
        ovr_clr = 1'b1;
        @(negedge clk);
        ovr_clr = 1'b0;
        chk("R9 overrun cleared", to_ovr, 0);
        to_line = 1'b1;

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule